// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches a single 16-bit word from a three-wire serial configuration EEPROM. A host pulses a start request with a 6-bit word address; the block then frames one complete read on the serial pins. It asserts the select line, sends the fixed read opcode and the address, clocks in the sixteen data bits and releases the select line. When it finishes, it presents the assembled word.

The serial bit period is set at build time by a divider parameter. Each phase of the serial clock lasts `PHASE_DIV` system clocks. A bit occupies three equal phases: clock low, clock high, clock low. One setup phase with the clock low comes before the first bit. A full read therefore keeps the block busy for `(1 + 3*25) * PHASE_DIV` system cycles. Requests that arrive while a read is in flight are dropped.

Top module: `eeprom_word_reader`

## Requirements
- R1: Out of reset and while idle, `ee_cs`, `ee_sclk`, `ee_sdi`, `rd_busy` and `rd_done` are all low.
- R2: A `rd_start` seen while idle is accepted at that clock edge. In the next cycle `rd_busy` and `ee_cs` are high and `ee_sclk` is low. `ee_sclk` then stays low for 2*PHASE_DIV cycles: one setup phase plus the leading low phase of the first bit.
- R3: The first nine serial bits on `ee_sdi`, taken at each rising `ee_sclk`, are the opcode 1, 1, 0 followed by the 6-bit address, most significant bit first. `ee_sdi` is low during the data bits.
- R4: Every serial bit consists of low, high and low phases of exactly PHASE_DIV cycles each. `ee_sdi` does not change while `ee_sclk` is high.
- R5: The 16 data bits are taken from `ee_sdo` in the last system cycle of each high phase, most significant bit first, and assembled into `rd_word`.
- R6: After the 25th bit, `ee_cs` falls with `ee_sclk` low. In the same cycle `rd_done` pulses for one cycle, `rd_busy` drops and `rd_word` holds the new word. `rd_busy` is high for exactly 76*PHASE_DIV cycles.
- R7: A `rd_start` that arrives while `rd_busy` is high is ignored. It changes neither the address being sent nor the frame length.
- R8: `ee_sclk` is never high while `ee_cs` is low, and each read produces exactly 25 rising edges of `ee_sclk`.
- R9: `rd_word` keeps its value after `rd_done` until the next read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_start | input | 1 | Read request pulse, accepted only when idle |
| rd_addr | input | 6 | Word address captured with the request |
| rd_busy | output | 1 | High while a read frame is in progress |
| rd_done | output | 1 | One-cycle pulse when the word is available |
| rd_word | output | 16 | Last word read |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sclk | output | 1 | EEPROM serial clock |
| ee_sdi | output | 1 | Serial data towards the EEPROM |
| ee_sdo | input | 1 | Serial data from the EEPROM |

## Verification
The bench sweeps every one of the 64 addresses against a behavioural EEPROM model. The model decodes the opcode and address from the pins and returns a word computed from the address. An off-by-one in the address shift or in the data-bit count would show up as a wrong word or a wrong rising-edge count. The bench measures the length of every clock phase, the lead-in before the first rising edge and the tail before select drops. A divider that wraps early, or a setup phase that was left out, changes those run lengths. It also injects a request mid-frame with the inverted address; a design that took the request would restart or resend the wrong address.

// File: rtl/eeprom_rd_pkg.sv
// Shared definitions for the serial EEPROM word reader.
// Assumes the three-wire read command: opcode, address, then data.
package eeprom_rd_pkg;
    localparam int         OP_W    = 3;
    localparam logic [2:0] READ_OP = 3'b110;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SETUP,
        FR_BIT
    } frame_state_e;

    typedef enum logic [1:0] {
        PH_LEAD,
        PH_HIGH,
        PH_TRAIL
    } bit_phase_e;
endpackage

// File: rtl/ee_phase_timer.sv
// Phase timer: produces a one-cycle tick at the end of each serial clock phase.
// Assumes run stays high for the whole frame; the counter clears when idle.
module ee_phase_timer #(
    parameter int PHASE_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (PHASE_DIV > 1) ? $clog2(PHASE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    // Count system cycles within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    a_r4_phase_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < PHASE_DIV);
endmodule

// File: rtl/ee_frame_ctrl.sv
// Frame controller: sequences the setup phase and the 25 three-phase bits,
// and decodes which bits transmit and which sample.
// Assumes tick comes from ee_phase_timer, which runs while busy.
module ee_frame_ctrl
    import eeprom_rd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic launch,
    output logic sclk,
    output logic tx_active,
    output logic tx_shift,
    output logic rx_sample,
    output logic finish,
    output logic done
);
    localparam int TX_BITS = OP_W + ADDR_W;
    localparam int N_BITS  = TX_BITS + DATA_W;
    localparam int BW      = $clog2(N_BITS + 1);

    frame_state_e state_q;
    bit_phase_e   phase_q;
    logic [BW-1:0] bit_q;
    logic          done_q;

    assign busy      = (state_q != FR_IDLE);
    assign launch    = (state_q == FR_IDLE) && start;
    assign sclk      = (state_q == FR_BIT) && (phase_q == PH_HIGH);
    assign tx_active = (state_q == FR_BIT) && (int'(bit_q) < TX_BITS);
    assign tx_shift  = tx_active && (phase_q == PH_TRAIL) && tick;
    assign rx_sample = (state_q == FR_BIT) && (int'(bit_q) >= TX_BITS)
                       && (phase_q == PH_HIGH) && tick;
    assign finish    = (state_q == FR_BIT) && (phase_q == PH_TRAIL) && tick
                       && (int'(bit_q) == N_BITS - 1);
    assign done      = done_q;

    // Advance state, phase and bit index at each phase tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            phase_q <= PH_LEAD;
            bit_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                FR_IDLE: begin
                    if (start) state_q <= FR_SETUP;
                end
                FR_SETUP: begin
                    if (tick) begin
                        state_q <= FR_BIT;
                        phase_q <= PH_LEAD;
                        bit_q   <= '0;
                    end
                end
                FR_BIT: begin
                    if (tick) begin
                        case (phase_q)
                            PH_LEAD: phase_q <= PH_HIGH;
                            PH_HIGH: phase_q <= PH_TRAIL;
                            default: begin
                                phase_q <= PH_LEAD;
                                if (finish) begin
                                    state_q <= FR_IDLE;
                                    done_q  <= 1'b1;
                                end else begin
                                    bit_q <= bit_q + 1'b1;
                                end
                            end
                        endcase
                    end
                end
                default: state_q <= FR_IDLE;
            endcase
        end
    end

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy && $past(busy)));
    a_r2_clock_low_at_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !sclk);
endmodule

// File: rtl/ee_word_shift.sv
// Data path: holds the outgoing opcode and address, collects the incoming bits
// and latches the finished word.
// Assumes launch, tx_shift, rx_sample and finish come from ee_frame_ctrl.
module ee_word_shift
    import eeprom_rd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] addr,
    input  logic              tx_shift,
    input  logic              rx_sample,
    input  logic              finish,
    input  logic              sdo,
    output logic              tx_bit,
    output logic [DATA_W-1:0] word
);
    localparam int TX_BITS = OP_W + ADDR_W;

    logic [TX_BITS-1:0] tx_q;
    logic [DATA_W-1:0]  rx_q;
    logic [DATA_W-1:0]  word_q;

    assign tx_bit = tx_q[TX_BITS-1];
    assign word   = word_q;

    // Load the command at launch and shift it out one bit per serial bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_q <= '0;
        else if (launch)   tx_q <= {READ_OP, addr};
        else if (tx_shift) tx_q <= {tx_q[TX_BITS-2:0], 1'b0};
    end

    // Collect incoming data bits, most significant first.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_q <= '0;
        else if (rx_sample) rx_q <= {rx_q[DATA_W-2:0], sdo};
    end

    // Latch the finished word for the host.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (finish) word_q <= rx_q;
    end

    a_r7_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch && !tx_shift) |=> $stable(tx_q));
    a_r9_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(word_q));
endmodule

// File: rtl/eeprom_word_reader.sv
// Serial EEPROM word reader top: one start request yields one framed
// read of a 16-bit word over select, clock, data-in and data-out.
// Assumes ee_sdo is stable during each high clock phase.
module eeprom_word_reader #(
    parameter int PHASE_DIV = 4,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_busy,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_word,
    output logic              ee_cs,
    output logic              ee_sclk,
    output logic              ee_sdi,
    input  logic              ee_sdo
);
    logic tick, launch, tx_active, tx_shift, rx_sample, finish, tx_bit;

    ee_phase_timer #(.PHASE_DIV(PHASE_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (rd_busy),
        .tick  (tick)
    );

    ee_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rd_start),
        .tick      (tick),
        .busy      (rd_busy),
        .launch    (launch),
        .sclk      (ee_sclk),
        .tx_active (tx_active),
        .tx_shift  (tx_shift),
        .rx_sample (rx_sample),
        .finish    (finish),
        .done      (rd_done)
    );

    ee_word_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .addr      (rd_addr),
        .tx_shift  (tx_shift),
        .rx_sample (rx_sample),
        .finish    (finish),
        .sdo       (ee_sdo),
        .tx_bit    (tx_bit),
        .word      (rd_word)
    );

    assign ee_cs  = rd_busy;
    assign ee_sdi = tx_active && tx_bit;

    a_r8_clock_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sclk |-> ee_cs);
    a_r4_sdi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sclk |-> $stable(ee_sdi));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_busy |-> (!ee_sdi && !ee_sclk));
endmodule

// File: tb/eeprom_word_reader_tb.sv
module eeprom_word_reader_tb;
    localparam int P      = 3;
    localparam int AW     = 6;
    localparam int DW     = 16;
    localparam int NB     = 3 + AW + DW;
    localparam int FRAME  = (1 + 3 * NB) * P;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, rd_start, rd_busy, rd_done, ee_cs, ee_sclk, ee_sdi, ee_sdo;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_word;

    int n_chk = 0, n_fail = 0;

    // Behavioural EEPROM and pin monitor state.
    bit          prev_cs = 0, prev_sk = 0;
    int          run = 0, rises = 0, falls = 0, last_rises = 0, mon_err = 0;
    logic [8:0]  cmd = '0;
    logic        di_hold = 1'b0;
    logic [DW-1:0] mw = '0;

    eeprom_word_reader #(.PHASE_DIV(P), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_addr(rd_addr),
        .rd_busy(rd_busy), .rd_done(rd_done), .rd_word(rd_word),
        .ee_cs(ee_cs), .ee_sclk(ee_sclk), .ee_sdi(ee_sdi), .ee_sdo(ee_sdo)
    );

    function automatic logic [DW-1:0] model_word(input logic [AW-1:0] a);
        logic [DW-1:0] w;
        w = ({10'd0, a} * 16'd1031) ^ 16'h9C35 ^ {a, 10'd0};
        return w;
    endfunction

    assign ee_sdo = (falls >= 9 && falls <= NB - 1) ? mw[NB - 1 - falls] : 1'b0;

    always @(negedge clk) begin
        if (!ee_cs && ee_sclk) mon_err++;
        if (ee_cs && !prev_cs) begin
            rises = 0; falls = 0; run = 1;
            if (ee_sclk) mon_err++;
        end else if (ee_cs) begin
            if (ee_sclk != prev_sk) begin
                if (prev_sk) begin
                    if (run != P) mon_err++;
                    falls++;
                end else begin
                    if (run != 2 * P) mon_err++;
                    if (rises < 9) cmd = {cmd[7:0], ee_sdi};
                    rises++;
                    if (rises == 9) mw = model_word(cmd[5:0]);
                    di_hold = ee_sdi;
                end
                run = 1;
            end else begin
                run++;
                if (ee_sclk && ee_sdi != di_hold) mon_err++;
            end
            if (ee_sclk && rises > 9 && ee_sdi) mon_err++;
        end else if (prev_cs) begin
            if (run != P) mon_err++;
            last_rises = rises;
            rises = 0; falls = 0;
        end
        prev_cs = ee_cs;
        prev_sk = ee_sclk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input bit poke);
        int busy_n = 0;
        int e0 = mon_err;
        rd_addr  = a;
        rd_start = 1'b1;
        step();
        rd_start = 1'b0;
        check(rd_busy && ee_cs && !ee_sclk, "R2 busy/select after start",
              {rd_busy, ee_cs, ee_sclk}, 3'b110);
        while (!rd_done && busy_n < FRAME + 20) begin
            if (rd_busy) busy_n++;
            if (poke && busy_n == 40) begin
                rd_start = 1'b1;
                rd_addr  = ~a;
            end else begin
                rd_start = 1'b0;
            end
            step();
        end
        rd_start = 1'b0;
        check(rd_word == model_word(a), "R5 word", rd_word, model_word(a));
        check(busy_n == FRAME, poke ? "R7 frame length with ignored start" : "R6 busy length",
              busy_n, FRAME);
        check(!rd_busy && !ee_cs && !ee_sclk, "R6 end state", {rd_busy, ee_cs, ee_sclk}, 0);
        check(cmd[8:6] == 3'b110, "R3 opcode", cmd[8:6], 3'b110);
        check(cmd[5:0] == a, poke ? "R7 address kept" : "R3 address", cmd[5:0], a);
        check(last_rises == NB, "R8 clock pulses", last_rises, NB);
        check(mon_err == e0, "R4 phase timing and data hold", mon_err - e0, 0);
        step();
        check(!rd_done, "R6 done single cycle", rd_done, 0);
        check(rd_word == model_word(a), "R9 word held", rd_word, model_word(a));
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rd_start = 1'b0; rd_addr = '0;
        step(); step(); step();
        check({ee_cs, ee_sclk, ee_sdi, rd_busy, rd_done} == 5'b0, "R1 in reset",
              {ee_cs, ee_sclk, ee_sdi, rd_busy, rd_done}, 0);
        rst_n = 1'b1;
        step(); step();
        check({ee_cs, ee_sclk, ee_sdi, rd_busy, rd_done} == 5'b0, "R1 idle after reset",
              {ee_cs, ee_sclk, ee_sdi, rd_busy, rd_done}, 0);
        check(rd_word == '0, "R1 word after reset", rd_word, 0);
        for (int a = 0; a < 64; a++) begin
            do_read(AW'(a), (a % 8) == 5);
        end
        for (int i = 0; i < 10; i++) step();
        check(rd_word == model_word(6'd63), "R9 word held while idle", rd_word, model_word(6'd63));
        check({ee_cs, ee_sclk, ee_sdi, rd_busy} == 4'b0, "R1 idle after sweep",
              {ee_cs, ee_sclk, ee_sdi, rd_busy}, 0);
        check(mon_err == 0, "R8 clock only under select", mon_err, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule